// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block produces the programmed-I/O read and write strobe sequence for one IDE channel. A host-side request names the target device (master or slave), the direction and the transfer width. The block then runs three timed phases: an address-valid phase with both strobes high, an active phase with the read or write strobe low, and a recovery phase with both strobes high again. A one-cycle done indication follows.

Each phase length comes from a 4-bit field that holds the number of clocks minus one. Every device has three timing bytes: one for 16-bit reads, one for 16-bit writes and one for 8-bit cycles. The high nibble of a byte sets the active length and the low nibble sets the recovery length. A shared setup word holds one setup nibble per device. A small register write port loads these fields, and a read port returns them. The timing used by a transfer is captured when the request is accepted.

Top module: `ide_pio_strobe_gen`

## Requirements
- R1: After reset, every timing byte reads 0xFF and the setup word reads 0x000000FF. Both strobes are high, and busy, done, addr_valid and dd_oe are low.
- R2: The configuration write port decodes cfg_addr as follows. 0 writes the full 32-bit setup word. 1 writes cfg_wdata[3:0] into setup bits [3:0]. 2 writes cfg_wdata[3:0] into setup bits [7:4]. 3, 4 and 5 write the master's 16-bit read, 16-bit write and 8-bit bytes from cfg_wdata[7:0]. 6, 7 and 8 write the same three bytes for the slave. A nibble write leaves every other bit of the setup word unchanged. Addresses 9 to 15 change nothing and read as 0. Addresses 1 and 2 read back their nibble, zero-extended.
- R3: A transfer accepted at a clock edge runs in this order. SETUP lasts S+1 cycles with addr_valid high and both strobes high. ACTIVE lasts A+1 cycles with one strobe low. RECOVERY lasts R+1 cycles with both strobes high. DONE then lasts one cycle.
- R4: S is setup bits [3:0] when req_dev=0 (master) and bits [7:4] when req_dev=1 (slave). A is bits [7:4] of the chosen timing byte, and R is bits [3:0] of that byte.
- R5: When req_wide=0 (8-bit), the device's 8-bit byte is used for both directions. When req_wide=1 (16-bit), the read byte is used if req_write=0 and the write byte is used if req_write=1.
- R6: During ACTIVE, a read (req_write=0) drives dior_n low and a write drives diow_n low. The two strobes are never low at the same time.
- R7: A request is accepted only in the idle state. busy is high from the cycle after acceptance through the last RECOVERY cycle. done is high for exactly the one cycle after that. A req_valid seen while the block is not idle is ignored.
- R8: For a write, dd_oe is high and dd_out equals the data captured at acceptance for exactly the ACTIVE cycles. At all other times dd_oe is low and dd_out is zero.
- R9: For a read, rd_data takes the dd_in value present in the last ACTIVE cycle and holds it until the next read. A write leaves rd_data unchanged.
- R10: A register write made while a transfer is in progress does not change the phase lengths of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read-back of the addressed register |
| req_valid | input | 1 | Transfer request |
| req_dev | input | 1 | 0 master, 1 slave |
| req_write | input | 1 | 0 read, 1 write |
| req_wide | input | 1 | 0 8-bit, 1 16-bit |
| req_wdata | input | 16 | Write data for the transfer |
| busy | output | 1 | Transfer in SETUP, ACTIVE or RECOVERY |
| done | output | 1 | One-cycle end-of-transfer pulse |
| addr_valid | output | 1 | Device address phase valid |
| dev_sel | output | 1 | Device of the current transfer |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_out | output | 16 | Drive-data output |
| dd_oe | output | 1 | Drive-data output enable |
| dd_in | input | 16 | Drive-data input |
| rd_data | output | 16 | Captured read data |

## Verification
Some properties are checked by assertions on every cycle:
- the two strobes are never low together;
- a strobe is low only inside the address-valid window;
- ACTIVE is entered only from SETUP;
- done is a single-cycle pulse with busy low;
- the captured timing stays stable while busy;
- nibble writes preserve the other bits, and unmapped writes change nothing.

Other behaviour can only be shown by the bench's scenarios:
- the exact phase lengths for each field value;
- which timing byte each width and direction combination selects;
- the read-sampling cycle;
- the rejection of requests that arrive while busy.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
  localparam int FIELD_W = 4;
  localparam int BYTE_W  = 2 * FIELD_W;

  // register map; the byte slots follow dev*3 + kind ordering
  localparam int ADDR_SETUP_WORD = 0;
  localparam int ADDR_SETUP_M    = 1;
  localparam int ADDR_SETUP_S    = 2;
  localparam int ADDR_BYTE_BASE  = 3;
  localparam int KINDS_PER_DEV   = 3;  // 0 wide read, 1 wide write, 2 narrow
  localparam int NUM_DEVS        = 2;
  localparam int NUM_BYTES       = NUM_DEVS * KINDS_PER_DEV;
  localparam int ADDR_LAST       = ADDR_BYTE_BASE + NUM_BYTES - 1;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_RECOV,
    PH_DONE
  } phase_e;

  typedef struct packed {
    logic [FIELD_W-1:0] setup;
    logic [FIELD_W-1:0] active;
    logic [FIELD_W-1:0] recov;
  } xfer_timing_t;
endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
  import ide_pio_pkg::*;
#(
  parameter int CFG_AW = 4,
  parameter int WORD_W = 32
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                cfg_we,
  input  logic [CFG_AW-1:0]                   cfg_addr,
  input  logic [WORD_W-1:0]                   cfg_wdata,
  output logic [WORD_W-1:0]                   cfg_rdata,
  output logic [WORD_W-1:0]                   setup_word,
  output logic [NUM_BYTES-1:0][BYTE_W-1:0]    tbytes
);
  localparam logic [WORD_W-1:0] SETUP_RST = WORD_W'({NUM_DEVS*FIELD_W{1'b1}});
  localparam logic [BYTE_W-1:0] BYTE_RST  = {BYTE_W{1'b1}};

  logic [WORD_W-1:0] setup_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      setup_q <= SETUP_RST;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_AW'(ADDR_SETUP_WORD))
        setup_q <= cfg_wdata;
      else if (cfg_addr == CFG_AW'(ADDR_SETUP_M))
        setup_q[FIELD_W-1:0] <= cfg_wdata[FIELD_W-1:0];
      else if (cfg_addr == CFG_AW'(ADDR_SETUP_S))
        setup_q[2*FIELD_W-1:FIELD_W] <= cfg_wdata[FIELD_W-1:0];
    end
  end

  for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_byte
    localparam logic [CFG_AW-1:0] MY_ADDR = CFG_AW'(ADDR_BYTE_BASE + gi);
    always_ff @(posedge clk) begin
      if (rst)
        tbytes[gi] <= BYTE_RST;
      else if (cfg_we && cfg_addr == MY_ADDR)
        tbytes[gi] <= cfg_wdata[BYTE_W-1:0];
    end
  end

  assign setup_word = setup_q;

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == CFG_AW'(ADDR_SETUP_WORD))
      cfg_rdata = setup_q;
    else if (cfg_addr == CFG_AW'(ADDR_SETUP_M))
      cfg_rdata = WORD_W'(setup_q[FIELD_W-1:0]);
    else if (cfg_addr == CFG_AW'(ADDR_SETUP_S))
      cfg_rdata = WORD_W'(setup_q[2*FIELD_W-1:FIELD_W]);
    else
      for (int i = 0; i < NUM_BYTES; i++)
        if (cfg_addr == CFG_AW'(ADDR_BYTE_BASE + i))
          cfg_rdata = WORD_W'(tbytes[i]);
  end

  // R2: a master nibble write keeps every upper bit
  a_r2_master_nibble_keeps: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == CFG_AW'(ADDR_SETUP_M))
      |=> (setup_q[WORD_W-1:FIELD_W] == $past(setup_q[WORD_W-1:FIELD_W])));

  // R2: a slave nibble write keeps the master nibble and bits above it
  a_r2_slave_nibble_keeps: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == CFG_AW'(ADDR_SETUP_S))
      |=> (setup_q[FIELD_W-1:0] == $past(setup_q[FIELD_W-1:0]) &&
           setup_q[WORD_W-1:2*FIELD_W] == $past(setup_q[WORD_W-1:2*FIELD_W])));

  // R2: unmapped writes change nothing
  a_r2_unmapped_ignored: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr > CFG_AW'(ADDR_LAST))
      |=> ($stable(setup_q) && $stable(tbytes)));
endmodule

// File: rtl/pio_field_select.sv
module pio_field_select
  import ide_pio_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0]                setup_word,
  input  logic [NUM_BYTES-1:0][BYTE_W-1:0] tbytes,
  input  logic                             dev,
  input  logic                             write,
  input  logic                             wide,
  output xfer_timing_t                     timing
);
  logic [1:0]        kind;
  logic [BYTE_W-1:0] chosen;

  always_comb begin
    if (!wide)      kind = 2'd2;
    else if (write) kind = 2'd1;
    else            kind = 2'd0;
    chosen = dev ? tbytes[KINDS_PER_DEV + 32'(kind)] : tbytes[32'(kind)];
    timing.setup  = dev ? setup_word[2*FIELD_W-1:FIELD_W] : setup_word[FIELD_W-1:0];
    timing.active = chosen[BYTE_W-1:FIELD_W];
    timing.recov  = chosen[FIELD_W-1:0];
  end
endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import ide_pio_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  xfer_timing_t      timing,
  input  logic              dev,
  input  logic              write,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] dd_in,
  output logic              busy,
  output logic              done,
  output logic              addr_valid,
  output logic              dev_sel,
  output logic              dior_n,
  output logic              diow_n,
  output logic [DATA_W-1:0] dd_out,
  output logic              dd_oe,
  output logic [DATA_W-1:0] rd_data
);
  phase_e             state;
  logic [FIELD_W-1:0] cnt;
  xfer_timing_t       t_q;
  logic               wr_q;
  logic               dev_q;
  logic [DATA_W-1:0]  wdat_q;
  logic [DATA_W-1:0]  rdat_q;
  logic               last;

  assign last = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= PH_IDLE;
      cnt    <= '0;
      t_q    <= '0;
      wr_q   <= 1'b0;
      dev_q  <= 1'b0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      unique case (state)
        PH_IDLE: if (start) begin
          state  <= PH_SETUP;
          cnt    <= timing.setup;
          t_q    <= timing;
          wr_q   <= write;
          dev_q  <= dev;
          wdat_q <= wdata;
        end
        PH_SETUP: if (last) begin
          state <= PH_ACTIVE;
          cnt   <= t_q.active;
        end else cnt <= cnt - 1'b1;
        PH_ACTIVE: if (last) begin
          state <= PH_RECOV;
          cnt   <= t_q.recov;
          if (!wr_q) rdat_q <= dd_in;
        end else cnt <= cnt - 1'b1;
        PH_RECOV: if (last) state <= PH_DONE;
                  else cnt <= cnt - 1'b1;
        PH_DONE:  state <= PH_IDLE;
        default:  state <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    busy       = (state == PH_SETUP) || (state == PH_ACTIVE) || (state == PH_RECOV);
    addr_valid = busy;
    done       = (state == PH_DONE);
    dior_n     = !((state == PH_ACTIVE) && !wr_q);
    diow_n     = !((state == PH_ACTIVE) && wr_q);
    dd_oe      = (state == PH_ACTIVE) && wr_q;
    dd_out     = dd_oe ? wdat_q : '0;
    dev_sel    = dev_q;
    rd_data    = rdat_q;
  end

  // R6: one strobe at a time
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!dior_n && !diow_n));

  // R3: strobes only inside the address window
  a_r3_strobe_in_window: assert property (@(posedge clk) disable iff (rst)
    (!dior_n || !diow_n) |-> addr_valid);

  // R3: ACTIVE is entered only from SETUP
  a_r3_active_after_setup: assert property (@(posedge clk) disable iff (rst)
    $rose(state == PH_ACTIVE) |-> ($past(state) == PH_SETUP));

  // R7: done is a lone pulse with busy low
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy ##1 !done));

  // R10: captured timing holds across a transfer
  a_r10_timing_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(t_q));

  // R8: the data bus is driven only under the write strobe
  a_r8_oe_under_strobe: assert property (@(posedge clk) disable iff (rst)
    dd_oe |-> !diow_n);
endmodule

// File: rtl/ide_pio_strobe_gen.sv
module ide_pio_strobe_gen
  import ide_pio_pkg::*;
#(
  parameter int CFG_AW = 4,
  parameter int WORD_W = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic              req_dev,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              addr_valid,
  output logic              dev_sel,
  output logic              dior_n,
  output logic              diow_n,
  output logic [DATA_W-1:0] dd_out,
  output logic              dd_oe,
  input  logic [DATA_W-1:0] dd_in,
  output logic [DATA_W-1:0] rd_data
);
  logic [WORD_W-1:0]                setup_word;
  logic [NUM_BYTES-1:0][BYTE_W-1:0] tbytes;
  xfer_timing_t                     sel_timing;

  pio_timing_regs #(.CFG_AW(CFG_AW), .WORD_W(WORD_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .setup_word(setup_word),
    .tbytes    (tbytes)
  );

  pio_field_select #(.WORD_W(WORD_W)) u_sel (
    .setup_word(setup_word),
    .tbytes    (tbytes),
    .dev       (req_dev),
    .write     (req_write),
    .wide      (req_wide),
    .timing    (sel_timing)
  );

  pio_phase_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (req_valid),
    .timing    (sel_timing),
    .dev       (req_dev),
    .write     (req_write),
    .wdata     (req_wdata),
    .dd_in     (dd_in),
    .busy      (busy),
    .done      (done),
    .addr_valid(addr_valid),
    .dev_sel   (dev_sel),
    .dior_n    (dior_n),
    .diow_n    (diow_n),
    .dd_out    (dd_out),
    .dd_oe     (dd_oe),
    .rd_data   (rd_data)
  );
endmodule

// File: tb/ide_pio_strobe_gen_test.sv
module ide_pio_strobe_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0, req_dev = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, addr_valid, dev_sel, dior_n, diow_n, dd_oe;
  logic [15:0] dd_out, rd_data;
  logic [15:0] dd_in = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] m_setup;
  logic [7:0]  m_byte [6];
  logic [15:0] m_rd;

  ide_pio_strobe_gen uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_dev(req_dev), .req_write(req_write), .req_wide(req_wide),
    .req_wdata(req_wdata), .busy(busy), .done(done), .addr_valid(addr_valid),
    .dev_sel(dev_sel), .dior_n(dior_n), .diow_n(diow_n), .dd_out(dd_out),
    .dd_oe(dd_oe), .dd_in(dd_in), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input int a);
    if (a == 0) return m_setup;
    if (a == 1) return {28'h0, m_setup[3:0]};
    if (a == 2) return {28'h0, m_setup[7:4]};
    if (a >= 3 && a <= 8) return {24'h0, m_byte[a-3]};
    return 32'h0;
  endfunction

  function automatic logic [15:0] din_f(input int k, input logic [15:0] salt);
    return salt ^ (16'(k) * 16'h0101);
  endfunction

  function automatic int byte_idx(input bit dev, input bit wr, input bit wide);
    return (dev ? 3 : 0) + (!wide ? 2 : (wr ? 1 : 0));
  endfunction

  task automatic model_write(input int a, input logic [31:0] d);
    if (a == 0) m_setup = d;
    else if (a == 1) m_setup[3:0] = d[3:0];
    else if (a == 2) m_setup[7:4] = d[3:0];
    else if (a >= 3 && a <= 8) m_byte[a-3] = d[7:0];
  endtask

  task automatic cfg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic check_all_regs(input string tag);
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      cfg_addr = 4'(a);
      #1;
      check(cfg_rdata == model_read(a), tag, $sformatf("readback addr %0d", a),
            cfg_rdata, model_read(a));
    end
  endtask

  // one transfer with per-cycle comparison of every output
  task automatic run_xfer(input bit dev, input bit wr, input bit wide,
                          input logic [15:0] data, input bit ign, input bit poke,
                          input string tag);
    int s, a, r, last, bi;
    bit bad_tim, bad_strb, bad_data;
    logic [15:0] salt;
    bi = byte_idx(dev, wr, wide);
    s = int'(dev ? m_setup[7:4] : m_setup[3:0]);
    a = int'(m_byte[bi][7:4]);
    r = int'(m_byte[bi][3:0]);
    last = s + a + r + 3;
    salt = 16'($urandom);
    bad_tim = 0; bad_strb = 0; bad_data = 0;
    @(negedge clk);
    req_valid = 1'b1; req_dev = dev; req_write = wr; req_wide = wide; req_wdata = data;
    for (int k = 0; k <= last; k++) begin
      bit act, exp_oe;
      @(negedge clk);
      if (k == 0) begin
        req_valid = ign;
        req_dev = ~dev; req_write = ~wr; req_wdata = ~data;
        if (poke) begin
          cfg_we = 1'b1; cfg_addr = 4'(3 + bi); cfg_wdata = {24'h0, 8'($urandom)};
        end
      end
      if (k == 1 && poke) begin
        cfg_we = 1'b0;
        model_write(int'(cfg_addr), cfg_wdata);
      end
      if (k == last) req_valid = 1'b0;
      dd_in = din_f(k, salt);
      act = (k > s) && (k <= s + a + 1);
      exp_oe = act && wr;
      if (addr_valid !== (k < last) || busy !== (k < last) || done !== (k == last) ||
          dev_sel !== dev)
        bad_tim = 1;
      if (dior_n !== !(act && !wr) || diow_n !== !(act && wr)) bad_strb = 1;
      if (dd_oe !== exp_oe || dd_out !== (exp_oe ? data : 16'h0)) bad_data = 1;
      if (k == last) begin
        if (!wr) m_rd = din_f(s + a + 1, salt);
        check(rd_data == m_rd, "R9", "rd_data at done", {16'h0, rd_data}, {16'h0, m_rd});
      end
    end
    check(!bad_tim, tag, $sformatf("phase timing S=%0d A=%0d R=%0d", s, a, r),
          {31'h0, bad_tim}, 32'h0);
    check(!bad_strb, "R6", "strobe choice/level", {31'h0, bad_strb}, 32'h0);
    check(!bad_data, "R8", "write data drive window", {31'h0, bad_data}, 32'h0);
    @(negedge clk);
    check(busy == 1'b0 && addr_valid == 1'b0 && done == 1'b0, "R7",
          "idle after done (late request ignored)",
          {29'h0, busy, addr_valid, done}, 32'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL R3 watchdog actual=hang expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_setup = 32'h0000_00FF;
    for (int i = 0; i < 6; i++) m_byte[i] = 8'hFF;
    m_rd = 16'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(dior_n && diow_n && !busy && !done && !addr_valid && !dd_oe, "R1",
          "idle outputs after reset",
          {26'h0, dior_n, diow_n, busy, done, addr_valid, dd_oe}, 32'h30);
    check_all_regs("R1");

    // R2 setup word and nibble writes, unmapped writes
    cfg_write(0, 32'hDEAD_BE21);
    cfg_write(1, 32'hFFFF_FFF7);
    cfg_write(2, 32'h0000_0003);
    for (int a = 9; a < 16; a++) cfg_write(a, 32'h1234_5678);
    @(negedge clk); cfg_addr = 4'd0; #1;
    check(cfg_rdata == 32'hDEAD_BE37, "R2", "nibble writes keep other bits",
          cfg_rdata, 32'hDEAD_BE37);
    check_all_regs("R2");

    // slowest default bytes, master 16-bit read (R3)
    run_xfer(1'b0, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0, "R3");
    // zero fields: shortest sequence (R3, R4)
    cfg_write(0, 32'h0);
    for (int i = 0; i < 6; i++) cfg_write(3 + i, 32'h0);
    run_xfer(1'b0, 1'b1, 1'b1, 16'hA5C3, 1'b0, 1'b0, "R3");
    run_xfer(1'b1, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, "R4");
    // distinct bytes per kind and device (R4, R5)
    cfg_write(0, 32'h0000_0052);
    cfg_write(3, 32'h13); cfg_write(4, 32'h31); cfg_write(5, 32'h24);
    cfg_write(6, 32'h42); cfg_write(7, 32'h05); cfg_write(8, 32'h50);
    for (int i = 0; i < 8; i++)
      run_xfer(i[0], i[1], i[2], 16'(16'h1111 * i), 1'b0, 1'b0, "R5");
    // request held during busy (R7) and mid-transfer register write (R10)
    run_xfer(1'b1, 1'b1, 1'b1, 16'h7E81, 1'b1, 1'b0, "R7");
    run_xfer(1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b1, "R10");
    // random mix
    for (int n = 0; n < 40; n++) begin
      if ($urandom_range(0, 1) == 1)
        cfg_write(int'($urandom_range(0, 8)), $urandom);
      run_xfer(1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
               1'($urandom), 1'($urandom), "R3");
    end
    check_all_regs("R2");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule